// File: doc/BRIEF.md
# Coin Vending State Machine

This block is the control core of a drink vending machine. Three coin buttons (5, 10 and 25 cents) add credit, counted in 5-cent steps, until at least 25 cents has been inserted. The machine then runs a fixed three-state dispense sequence that lights the LEDs and the all-segments display pattern twice, with a dark state in between. After the sequence it returns to zero credit. A clear button empties the credit from any state.

Every coin button passes through a rising-edge detector, so holding a button down counts as one coin. When several new presses arrive on the same clock edge, only one coin is accepted. The outputs depend only on the state register, so they are a Moore decode: an LED vector, a segment vector covering every digit, and the 3-bit state code for display.

Top module: `coin_vend_fsm`

## Requirements
- R1: While `rst_ni` is low, the state code is 0 (zero credit) and `led_o` and `seg_o` are all zeros, without waiting for a clock edge. The edge detectors also clear, so a button that is already high at the first edge after reset counts as a new press.
- R2: When `clear_i` is high on a clock edge, the state becomes 0 on that edge, whatever the current state and whatever the coin inputs are.
- R3: In a credit state, a new coin press moves the state to the code for the new credit. The credit states are 0, 1, 2, 3 and 4, meaning 0, 5, 10, 15 and 20 cents. A nickel adds 1 to the code, a dime adds 2 and a quarter adds 5. `state_o` always shows the current state code.
- R4: Whenever the new credit would reach 25 cents or more, the state becomes 5 (enough credit). The code never goes above 5 as a result of a coin.
- R5: When more than one new press arrives on the same edge, only one coin is counted: a quarter beats a dime, and a dime beats a nickel.
- R6: A coin counts only on the edge where its button is first seen high after being low. A held button adds nothing more until it has been released and pressed again.
- R7: Unless clear is high, the states advance 5 to 6, 6 to 7 and 7 to 0 on successive edges. Coin presses have no effect on the state while in 5, 6 or 7.
- R8: `led_o` and `seg_o` are all ones in states 5 and 7 and all zeros in every other state, so each dispense gives two flashes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Clear-credit button, synchronous, level sensitive |
| nickel_i | input | 1 | 5-cent coin button |
| dime_i | input | 1 | 10-cent coin button |
| quarter_i | input | 1 | 25-cent coin button |
| led_o | output | NUM_LEDS (8) | LED enables, all on during a flash |
| seg_o | output | 7*NUM_DIGITS (28) | Segment enables for all digits, all on during a flash |
| state_o | output | 3 | Current state code |

## Verification
The assertions assume that the coin and clear inputs are synchronous to `clk_i` and already debounced, so that each level change is a real press or release. The stimulus meets this by changing inputs only on the falling clock edge. Buttons are held at random for several cycles, pressed together and released at random, and clear is kept rare so that full credit and dispense runs happen often.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [2:0] {
    ST_ZERO   = 3'd0,
    ST_C5     = 3'd1,
    ST_C10    = 3'd2,
    ST_C15    = 3'd3,
    ST_C20    = 3'd4,
    ST_FULL   = 3'd5,
    ST_VEND_A = 3'd6,
    ST_VEND_B = 3'd7
  } vend_state_e;

  localparam int unsigned NUM_COINS = 3;  // index 0 nickel, 1 dime, 2 quarter
  localparam int unsigned FULL_U    = 5;  // credit units (5 cents) for a vend

  function automatic logic [3:0] coin_units(input int unsigned idx);
    case (idx)
      0:       coin_units = 4'd1;
      1:       coin_units = 4'd2;
      default: coin_units = 4'd5;
    endcase
  endfunction
endpackage

// File: rtl/coin_rise_det.sv
module coin_rise_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] btn_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= btn_i[g];
    end
    assign rise_o[g] = btn_i[g] & ~prev_q;

    AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]); // R6
  end
endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
  import vend_pkg::*;
(
  input  vend_state_e          state_i,
  input  logic                 clear_i,
  input  logic [NUM_COINS-1:0] rise_i,
  output vend_state_e          state_o
);
  logic [3:0] add_u;
  logic [3:0] sum_u;
  logic       any_coin;

  // later index wins: quarter > dime > nickel
  always_comb begin
    add_u    = '0;
    any_coin = 1'b0;
    for (int i = 0; i < NUM_COINS; i++) begin
      if (rise_i[i]) begin
        add_u    = coin_units(i);
        any_coin = 1'b1;
      end
    end
  end

  assign sum_u = {1'b0, state_i} + add_u;

  always_comb begin
    state_o = state_i;
    if (clear_i) begin
      state_o = ST_ZERO;
    end else begin
      case (state_i)
        ST_FULL:   state_o = ST_VEND_A;
        ST_VEND_A: state_o = ST_VEND_B;
        ST_VEND_B: state_o = ST_ZERO;
        default: begin
          if (any_coin) begin
            if (sum_u >= 4'(FULL_U)) state_o = ST_FULL;
            else                     state_o = vend_state_e'(sum_u[2:0]);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vend_out_decode.sv
module vend_out_decode
  import vend_pkg::*;
#(
  parameter int unsigned NUM_LEDS   = 8,
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned SEG_W     = 7 * NUM_DIGITS
) (
  input  vend_state_e         state_i,
  output logic [NUM_LEDS-1:0] led_o,
  output logic [SEG_W-1:0]    seg_o,
  output logic [2:0]          code_o
);
  logic flash;
  assign flash  = (state_i == ST_FULL) || (state_i == ST_VEND_B);
  assign led_o  = {NUM_LEDS{flash}};
  assign seg_o  = {SEG_W{flash}};
  assign code_o = state_i;
endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
  import vend_pkg::*;
#(
  parameter int unsigned NUM_LEDS   = 8,
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned SEG_W     = 7 * NUM_DIGITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                nickel_i,
  input  logic                dime_i,
  input  logic                quarter_i,
  output logic [NUM_LEDS-1:0] led_o,
  output logic [SEG_W-1:0]    seg_o,
  output logic [2:0]          state_o
);
  logic [NUM_COINS-1:0] rise;
  vend_state_e          state_q, state_d;

  coin_rise_det #(.N(NUM_COINS)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  ({quarter_i, dime_i, nickel_i}),
    .rise_o (rise)
  );

  vend_next_state u_next (
    .state_i (state_q),
    .clear_i (clear_i),
    .rise_i  (rise),
    .state_o (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ZERO;
    else         state_q <= state_d;
  end

  vend_out_decode #(.NUM_LEDS(NUM_LEDS), .NUM_DIGITS(NUM_DIGITS)) u_out (
    .state_i (state_q),
    .led_o   (led_o),
    .seg_o   (seg_o),
    .code_o  (state_o)
  );

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> state_o == 3'd0); // R2
  AST_FULL_TO_VEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && !clear_i) |=> state_o == 3'd6); // R7
  AST_VEND_A_TO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && !clear_i) |=> state_o == 3'd7); // R7
  AST_VEND_B_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd7 && !clear_i) |=> state_o == 3'd0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o < 3'd5 && !clear_i && rise == '0) |=> $stable(state_o)); // R6
  AST_ONE_COIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o < 3'd5 && !clear_i && rise != '0) |=>
      (state_o > $past(state_o) && state_o <= 3'd5)); // R4
  AST_DARK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd6 |-> (led_o == '0 && seg_o == '0)); // R8
  AST_FLASH_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 || state_o == 3'd7) |-> (&led_o && &seg_o)); // R8
endmodule

// File: tb/coin_vend_fsm_bench.sv
`timescale 1ns/1ps
module coin_vend_fsm_bench;
  localparam int NL = 8;
  localparam int SW = 28;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          clear_i = 1'b0, nickel_i = 1'b0, dime_i = 1'b0, quarter_i = 1'b0;
  logic [NL-1:0] led_o;
  logic [SW-1:0] seg_o;
  logic [2:0]    state_o;

  int n_run = 0, n_fail = 0;
  int m_st = 0;
  logic pn = 0, pd = 0, pq = 0;
  string m_tag;

  always #2 clk_i = ~clk_i;

  coin_vend_fsm u_coin_vend_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .nickel_i(nickel_i),
    .dime_i(dime_i), .quarter_i(quarter_i), .led_o(led_o), .seg_o(seg_o),
    .state_o(state_o)
  );

  // expected next state computed in cents
  function automatic int model_next(int st, logic c, logic n, logic d, logic q,
                                    logic p_n, logic p_d, logic p_q, output string tag);
    int add;
    int cents;
    if (c) begin tag = "R2"; return 0; end
    if (st >= 5) begin tag = "R7"; return (st == 7) ? 0 : st + 1; end
    add = 0;
    if (n && !p_n) add = 5;
    if (d && !p_d) add = 10;
    if (q && !p_q) add = 25;
    cents = st * 5 + add;
    if (add == 0) begin tag = "R6"; return st; end
    if (cents >= 25) begin tag = "R4"; return 5; end
    tag = "R3";
    return cents / 5;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    logic fl;
    fl = (m_st == 5 || m_st == 7);
    check("R8", int'(&led_o && &seg_o), int'(fl));
    check("R8", int'(led_o == '0 && seg_o == '0), int'(!fl));
  endtask

  task automatic step(logic c, logic n, logic d, logic q);
    @(negedge clk_i);
    clear_i = c; nickel_i = n; dime_i = d; quarter_i = q;
    @(posedge clk_i);
    #1;
    m_st = model_next(m_st, c, n, d, q, pn, pd, pq, m_tag);
    pn = n; pd = d; pq = q;
    check(m_tag, int'(state_o), m_st);
    check_outs();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    check("R1", int'(state_o), 0);
    check("R1", int'(led_o == '0 && seg_o == '0), 1);
    m_st = 0; pn = 0; pd = 0; pq = 0;
    clear_i = 0; nickel_i = 0; dime_i = 0; quarter_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic n, d, q, c;
    void'($urandom(32'd1234));
    #5;
    check("R1", int'(state_o), 0);
    check("R1", int'(led_o == '0 && seg_o == '0), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6: held nickel counts once
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0);
    check("R6", int'(state_o), 1);
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    check("R6", int'(state_o), 2);
    // R5: dime and nickel together, dime wins
    step(0, 0, 0, 0);
    step(0, 1, 1, 0);
    check("R5", int'(state_o), 4);
    // R4: 20 + dime saturates
    step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    check("R4", int'(state_o), 5);
    // R7: new presses during vend ignored
    step(0, 1, 0, 1);
    check("R7", int'(state_o), 6);
    step(0, 0, 0, 0);
    check("R7", int'(state_o), 7);
    step(0, 0, 1, 0);
    check("R7", int'(state_o), 0);
    // R5: all three together from zero, quarter wins
    step(0, 0, 0, 0);
    step(0, 1, 1, 1);
    check("R5", int'(state_o), 5);
    // R2: clear overrides vend and coins
    step(1, 0, 0, 0);
    check("R2", int'(state_o), 0);
    step(0, 0, 1, 0);
    check("R3", int'(state_o), 2);
    step(1, 1, 0, 1);
    check("R2", int'(state_o), 0);
    // R1: async reset mid run, then a held button counts as new
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    do_reset();
    step(0, 1, 0, 0);
    check("R1", int'(state_o), 1);

    for (int i = 0; i < 4000; i++) begin
      c = ($urandom % 40) == 0;
      n = ($urandom % 4) == 0 ? ~nickel_i : nickel_i;
      d = ($urandom % 5) == 0 ? ~dime_i : dime_i;
      q = ($urandom % 9) == 0 ? ~quarter_i : quarter_i;
      step(c, n, d, q);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule